// File: doc/BRIEF.md
# Programmable Pad Cell Control Logic

This block holds the digital logic that sits between one package pad and the core. On the receive side, the pad value can optionally pass through a fixed delay. It is then stored in a capture element that acts either as an edge-triggered flip-flop or as a level-sensitive transparent latch. Two receive outputs each pick, independently, the live pad value or the stored value.

On the drive side, core data can be inverted. It then reaches the pad either directly or through an edge-triggered flip-flop. A drive-enable output, with its own polarity bit, tells the pad buffer when to drive. The receive and drive storage elements run from separate clocks, and each clock has a polarity bit. A shared global set/reset overrides both storage elements, and a per-element bit chooses whether that override sets or clears the element.

All of these choices are static configuration inputs. The whole model runs on one fast clock `clk_i`. The receive and drive clocks are sampled as ordinary signals and their edges are detected in that domain, which keeps the model synthesizable.

Top module: `pad_cell_logic`

## Requirements
- R1: While `rst_ni` is low, and until the first capture after it rises, both storage elements hold 0 and every stage of the delay line holds 0.
- R2: In flip-flop mode (`cfg_rx_latch_i`=0), the receive element loads the selected data only in the fast cycle where the effective receive clock level (`rx_clk_i` XOR `cfg_rx_clk_inv_i`) is 1 after being 0 in the previous fast cycle. In every other cycle it holds.
- R3: In latch mode (`cfg_rx_latch_i`=1), the receive element loads the selected data on every fast cycle in which the effective receive clock level is 1. It holds while that level is 0.
- R4: With `cfg_rx_dly_i`=1, the data offered to the receive element is the value `pad_i` had DELAY_CYC fast-clock edges earlier. With `cfg_rx_dly_i`=0, it is the current `pad_i`.
- R5: `rx_a_o` shows the stored receive value when `cfg_rx_a_reg_i`=1 and the live `pad_i` when it is 0. `rx_b_o` makes the same choice under `cfg_rx_b_reg_i`. The two selections are independent.
- R6: With `cfg_tx_reg_i`=0, `pad_o` equals `tx_data_i` XOR `cfg_tx_inv_i` in the same cycle.
- R7: With `cfg_tx_reg_i`=1, `pad_o` shows the drive element. That element loads `tx_data_i` XOR `cfg_tx_inv_i` when the effective drive clock level (`tx_clk_i` XOR `cfg_tx_clk_inv_i`) goes from 0 to 1, and holds otherwise.
- R8: Setting a clock's polarity bit to 1 moves capture to the falling edge of that raw clock. In latch mode it makes the element transparent while the raw receive clock is low.
- R9: `pad_en_o` equals `oe_i` XOR `cfg_oe_inv_i`. The receive side samples `pad_i` whatever the state of `pad_en_o`.
- R10: In every fast cycle in which `gsr_i` is 1, the receive element is forced to `cfg_rx_gsr_set_i` and the drive element to `cfg_tx_gsr_set_i`, overriding any capture. After `gsr_i` falls, each element keeps that value until its next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast model clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gsr_i | input | 1 | Global set/reset, active high |
| cfg_rx_latch_i | input | 1 | 1: receive element is a transparent latch |
| cfg_rx_dly_i | input | 1 | 1: insert the fixed delay before the receive element |
| cfg_rx_a_reg_i | input | 1 | 1: rx_a_o shows the stored value |
| cfg_rx_b_reg_i | input | 1 | 1: rx_b_o shows the stored value |
| cfg_rx_clk_inv_i | input | 1 | Receive clock polarity |
| cfg_rx_gsr_set_i | input | 1 | Value forced into the receive element by gsr_i |
| cfg_tx_clk_inv_i | input | 1 | Drive clock polarity |
| cfg_tx_inv_i | input | 1 | Invert drive data |
| cfg_tx_reg_i | input | 1 | 1: pad_o comes from the drive flip-flop |
| cfg_oe_inv_i | input | 1 | Invert drive enable |
| cfg_tx_gsr_set_i | input | 1 | Value forced into the drive element by gsr_i |
| rx_clk_i | input | 1 | Receive clock, sampled by clk_i |
| tx_clk_i | input | 1 | Drive clock, sampled by clk_i |
| pad_i | input | 1 | Value present on the pad |
| tx_data_i | input | 1 | Core data to drive |
| oe_i | input | 1 | Core drive enable |
| rx_a_o | output | 1 | First receive output |
| rx_b_o | output | 1 | Second receive output |
| pad_o | output | 1 | Value for the pad driver |
| pad_en_o | output | 1 | Pad driver enable (0 leaves the pad undriven) |

## Verification
The hardest situation to reach is a latch-mode capture with the delay switched in, overlapped by a global set/reset pulse. Reaching it needs a delayed pad value, an open latch window and an override, all in one stretch of cycles. The stimulus drives the pad, the data and the enable from a pseudo-random sequence. It toggles the two clocks at unrelated divide ratios and, in one phase, pulses `gsr_i` at random points, so overrides land inside open latch windows and beside drive clock edges. A behavioural model in the bench, holding the delay line as a queue, predicts all four outputs on every cycle.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef struct packed {
        logic latch_mode;
        logic dly_en;
        logic a_reg;
        logic b_reg;
        logic clk_inv;
        logic gsr_val;
    } rx_cfg_t;

    typedef struct packed {
        logic clk_inv;
        logic data_inv;
        logic reg_sel;
        logic oe_inv;
        logic gsr_val;
    } tx_cfg_t;

endpackage

// File: rtl/pcl_edge_det.sv
module pcl_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    input  logic inv_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic lvl;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        level_o    = sig_i ^ inv_i;
        rise_o     = level_o & ~st_q.lvl;
        st_d       = st_q;
        st_d.lvl   = level_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcl_delay_line.sv
module pcl_delay_line #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [LAST:0] taps;
    } dly_st_t;

    dly_st_t st_d, st_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.taps = din_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d      = st_q;
                st_d.taps = {st_q.taps[LAST-1:0], din_i};
            end
        end
    endgenerate

    assign dout_o = st_q.taps[LAST];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcl_rx_stage.sv
module pcl_rx_stage
    import pcl_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 4
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    gsr_i,
    input  rx_cfg_t cfg_i,
    input  logic    rx_clk_i,
    input  logic    pad_i,
    output logic    rx_a_o,
    output logic    rx_b_o
);
    typedef struct packed {
        logic store;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   clk_lvl;
    logic   clk_rise;
    logic   pad_late;
    logic   cap_data;
    logic   cap_en;

    pcl_edge_det u_rx_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sig_i   (rx_clk_i),
        .inv_i   (cfg_i.clk_inv),
        .level_o (clk_lvl),
        .rise_o  (clk_rise)
    );

    pcl_delay_line #(
        .DEPTH (DELAY_CYC)
    ) u_rx_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (pad_i),
        .dout_o (pad_late)
    );

    always_comb begin
        cap_data = cfg_i.dly_en ? pad_late : pad_i;
        cap_en   = cfg_i.latch_mode ? clk_lvl : clk_rise;
        st_d     = st_q;
        if (gsr_i) begin
            st_d.store = cfg_i.gsr_val;
        end else if (cap_en) begin
            st_d.store = cap_data;
        end
        rx_a_o = cfg_i.a_reg ? st_q.store : pad_i;
        rx_b_o = cfg_i.b_reg ? st_q.store : pad_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pcl_tx_stage.sv
module pcl_tx_stage
    import pcl_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    gsr_i,
    input  tx_cfg_t cfg_i,
    input  logic    tx_clk_i,
    input  logic    tx_data_i,
    input  logic    oe_i,
    output logic    pad_o,
    output logic    pad_en_o
);
    typedef struct packed {
        logic store;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic   clk_lvl;
    logic   clk_rise;
    logic   data_pol;

    pcl_edge_det u_tx_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sig_i   (tx_clk_i),
        .inv_i   (cfg_i.clk_inv),
        .level_o (clk_lvl),
        .rise_o  (clk_rise)
    );

    always_comb begin
        data_pol = tx_data_i ^ cfg_i.data_inv;
        st_d     = st_q;
        if (gsr_i) begin
            st_d.store = cfg_i.gsr_val;
        end else if (clk_rise) begin
            st_d.store = data_pol;
        end
        pad_o    = cfg_i.reg_sel ? st_q.store : data_pol;
        pad_en_o = oe_i ^ cfg_i.oe_inv;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_lvl;
    assign unused_lvl = clk_lvl;
endmodule

// File: rtl/pad_cell_logic.sv
module pad_cell_logic
    import pcl_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gsr_i,
    input  logic cfg_rx_latch_i,
    input  logic cfg_rx_dly_i,
    input  logic cfg_rx_a_reg_i,
    input  logic cfg_rx_b_reg_i,
    input  logic cfg_rx_clk_inv_i,
    input  logic cfg_rx_gsr_set_i,
    input  logic cfg_tx_clk_inv_i,
    input  logic cfg_tx_inv_i,
    input  logic cfg_tx_reg_i,
    input  logic cfg_oe_inv_i,
    input  logic cfg_tx_gsr_set_i,
    input  logic rx_clk_i,
    input  logic tx_clk_i,
    input  logic pad_i,
    input  logic tx_data_i,
    input  logic oe_i,
    output logic rx_a_o,
    output logic rx_b_o,
    output logic pad_o,
    output logic pad_en_o
);
    rx_cfg_t rx_cfg;
    tx_cfg_t tx_cfg;

    always_comb begin
        rx_cfg.latch_mode = cfg_rx_latch_i;
        rx_cfg.dly_en     = cfg_rx_dly_i;
        rx_cfg.a_reg      = cfg_rx_a_reg_i;
        rx_cfg.b_reg      = cfg_rx_b_reg_i;
        rx_cfg.clk_inv    = cfg_rx_clk_inv_i;
        rx_cfg.gsr_val    = cfg_rx_gsr_set_i;
        tx_cfg.clk_inv    = cfg_tx_clk_inv_i;
        tx_cfg.data_inv   = cfg_tx_inv_i;
        tx_cfg.reg_sel    = cfg_tx_reg_i;
        tx_cfg.oe_inv     = cfg_oe_inv_i;
        tx_cfg.gsr_val    = cfg_tx_gsr_set_i;
    end

    pcl_rx_stage #(
        .DELAY_CYC (DELAY_CYC)
    ) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .gsr_i    (gsr_i),
        .cfg_i    (rx_cfg),
        .rx_clk_i (rx_clk_i),
        .pad_i    (pad_i),
        .rx_a_o   (rx_a_o),
        .rx_b_o   (rx_b_o)
    );

    pcl_tx_stage u_tx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .gsr_i     (gsr_i),
        .cfg_i     (tx_cfg),
        .tx_clk_i  (tx_clk_i),
        .tx_data_i (tx_data_i),
        .oe_i      (oe_i),
        .pad_o     (pad_o),
        .pad_en_o  (pad_en_o)
    );
endmodule

// File: rtl/pad_cell_logic_chk.sv
module pad_cell_logic_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic gsr_i,
    input logic cfg_rx_latch_i,
    input logic cfg_rx_a_reg_i,
    input logic cfg_rx_clk_inv_i,
    input logic cfg_rx_gsr_set_i,
    input logic cfg_tx_clk_inv_i,
    input logic cfg_tx_inv_i,
    input logic cfg_tx_reg_i,
    input logic cfg_oe_inv_i,
    input logic cfg_tx_gsr_set_i,
    input logic rx_clk_i,
    input logic tx_clk_i,
    input logic tx_data_i,
    input logic oe_i,
    input logic rx_a_o,
    input logic pad_o,
    input logic pad_en_o
);
    logic rx_lvl_q, tx_lvl_q;
    logic rx_hold_q, tx_hold_q;
    logic gsr_seen_q, rx_set_q, tx_set_q;
    logic rx_lvl, tx_lvl;

    assign rx_lvl = rx_clk_i ^ cfg_rx_clk_inv_i;
    assign tx_lvl = tx_clk_i ^ cfg_tx_clk_inv_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_lvl_q   <= 1'b0;
            tx_lvl_q   <= 1'b0;
            rx_hold_q  <= 1'b0;
            tx_hold_q  <= 1'b0;
            gsr_seen_q <= 1'b0;
            rx_set_q   <= 1'b0;
            tx_set_q   <= 1'b0;
        end else begin
            rx_lvl_q   <= rx_lvl;
            tx_lvl_q   <= tx_lvl;
            rx_hold_q  <= !cfg_rx_latch_i && cfg_rx_a_reg_i && !gsr_i && !(rx_lvl && !rx_lvl_q);
            tx_hold_q  <= cfg_tx_reg_i && !gsr_i && !(tx_lvl && !tx_lvl_q);
            gsr_seen_q <= gsr_i;
            rx_set_q   <= cfg_rx_gsr_set_i;
            tx_set_q   <= cfg_tx_gsr_set_i;
        end
    end

    // R2
    rx_flop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_hold_q && cfg_rx_a_reg_i) |-> $stable(rx_a_o));

    // R7
    tx_flop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_hold_q && cfg_tx_reg_i) |-> $stable(pad_o));

    // R10
    rx_gsr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gsr_seen_q && cfg_rx_a_reg_i) |-> (rx_a_o == rx_set_q));

    // R10
    tx_gsr_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gsr_seen_q && cfg_tx_reg_i) |-> (pad_o == tx_set_q));

    // R9
    oe_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_oe_inv_i |-> (pad_en_o != oe_i));

    // R6
    tx_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_tx_reg_i && !cfg_tx_inv_i) |-> (pad_o == tx_data_i));
endmodule

bind pad_cell_logic pad_cell_logic_chk chk_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .gsr_i            (gsr_i),
    .cfg_rx_latch_i   (cfg_rx_latch_i),
    .cfg_rx_a_reg_i   (cfg_rx_a_reg_i),
    .cfg_rx_clk_inv_i (cfg_rx_clk_inv_i),
    .cfg_rx_gsr_set_i (cfg_rx_gsr_set_i),
    .cfg_tx_clk_inv_i (cfg_tx_clk_inv_i),
    .cfg_tx_inv_i     (cfg_tx_inv_i),
    .cfg_tx_reg_i     (cfg_tx_reg_i),
    .cfg_oe_inv_i     (cfg_oe_inv_i),
    .cfg_tx_gsr_set_i (cfg_tx_gsr_set_i),
    .rx_clk_i         (rx_clk_i),
    .tx_clk_i         (tx_clk_i),
    .tx_data_i        (tx_data_i),
    .oe_i             (oe_i),
    .rx_a_o           (rx_a_o),
    .pad_o            (pad_o),
    .pad_en_o         (pad_en_o)
);

// File: tb/pad_cell_logic_tb_top.sv
`timescale 1ns/1ps
module pad_cell_logic_tb_top;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gsr = 1'b0;
    logic c_latch = 1'b0, c_dly = 1'b0, c_areg = 1'b0, c_breg = 1'b0;
    logic c_rxinv = 1'b0, c_rxset = 1'b0, c_txinv_clk = 1'b0, c_txinv = 1'b0;
    logic c_txreg = 1'b0, c_oeinv = 1'b0, c_txset = 1'b0;
    logic rx_clk = 1'b0, tx_clk = 1'b0, pad = 1'b0, tx_data = 1'b0, oe = 1'b0;
    logic rx_a, rx_b, pad_out, pad_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    pad_cell_logic #(.DELAY_CYC(DLY)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .gsr_i(gsr),
        .cfg_rx_latch_i(c_latch), .cfg_rx_dly_i(c_dly),
        .cfg_rx_a_reg_i(c_areg), .cfg_rx_b_reg_i(c_breg),
        .cfg_rx_clk_inv_i(c_rxinv), .cfg_rx_gsr_set_i(c_rxset),
        .cfg_tx_clk_inv_i(c_txinv_clk), .cfg_tx_inv_i(c_txinv),
        .cfg_tx_reg_i(c_txreg), .cfg_oe_inv_i(c_oeinv),
        .cfg_tx_gsr_set_i(c_txset),
        .rx_clk_i(rx_clk), .tx_clk_i(tx_clk), .pad_i(pad),
        .tx_data_i(tx_data), .oe_i(oe),
        .rx_a_o(rx_a), .rx_b_o(rx_b), .pad_o(pad_out), .pad_en_o(pad_en)
    );

    // behavioural reference
    bit m_rx, m_tx, m_rx_prev, m_tx_prev;
    bit hist[$];

    task automatic model_clear();
        m_rx = 0; m_tx = 0; m_rx_prev = 0; m_tx_prev = 0;
        hist = {};
        for (int k = 0; k < DLY; k++) hist.push_back(1'b0);
    endtask

    initial model_clear();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit rl, tl, din;
            rl  = rx_clk ^ c_rxinv;
            tl  = tx_clk ^ c_txinv_clk;
            din = c_dly ? hist[0] : pad;
            if (gsr) m_rx = c_rxset;
            else if (c_latch ? rl : (rl && !m_rx_prev)) m_rx = din;
            if (gsr) m_tx = c_txset;
            else if (tl && !m_tx_prev) m_tx = tx_data ^ c_txinv;
            m_rx_prev = rl;
            m_tx_prev = tl;
            hist.push_back(pad);
            void'(hist.pop_front());
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "rx_a", rx_a, c_areg ? m_rx : pad);
            chk(cur_req, "rx_b", rx_b, c_breg ? m_rx : pad);
            chk(cur_req, "pad_o", pad_out, c_txreg ? m_tx : (tx_data ^ c_txinv));
            chk(cur_req, "pad_en", pad_en, oe ^ c_oeinv);
        end
    end

    task automatic run(int n, int rdiv, int tdiv, bit use_gsr);
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #1;
            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pad     = lfsr[0];
            tx_data = lfsr[3];
            oe      = lfsr[7];
            if (c % rdiv == 0) rx_clk = ~rx_clk;
            if (c % tdiv == 0) tx_clk = ~tx_clk;
            gsr     = use_gsr && (lfsr[11] & lfsr[12] & lfsr[14]);
        end
        @(posedge clk); #1;
        gsr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state seen through the registered paths
        c_areg = 1; c_breg = 1; c_txreg = 1;
        #1;
        @(negedge clk);
        chk("R1", "rx_a reset", rx_a, 1'b0);
        chk("R1", "pad_o reset", pad_out, 1'b0);
        @(posedge clk); #1;
        rst_n = 1;
        run(20, 7, 5, 0);

        cur_req = "R2"; c_latch = 0; c_dly = 0; c_areg = 1; c_breg = 0; c_txreg = 0;
        run(150, 3, 4, 0);
        cur_req = "R3"; c_latch = 1;
        run(150, 5, 3, 0);
        cur_req = "R4"; c_latch = 0; c_dly = 1;
        run(150, 2, 6, 0);
        cur_req = "R5"; c_latch = 1; c_areg = 0; c_breg = 1;
        run(150, 4, 3, 0);
        cur_req = "R6"; c_txreg = 0; c_txinv = 1; c_oeinv = 1;
        run(150, 3, 5, 0);
        cur_req = "R7"; c_txreg = 1; c_txinv = 0; c_oeinv = 0; c_areg = 1;
        run(150, 6, 3, 0);
        cur_req = "R8"; c_rxinv = 1; c_txinv_clk = 1; c_txinv = 1; c_latch = 0;
        run(150, 3, 2, 0);
        c_latch = 1;
        run(100, 5, 4, 0);
        cur_req = "R9"; c_oeinv = 1; c_rxinv = 0; c_txinv_clk = 0;
        run(150, 4, 4, 0);
        cur_req = "R10"; c_rxset = 1; c_txset = 0; c_latch = 1; c_dly = 1;
        run(300, 3, 5, 1);
        c_rxset = 0; c_txset = 1; c_latch = 0;
        run(300, 4, 3, 1);
        // R10: explicit override check, both clocks idle
        @(posedge clk); #1;
        gsr = 1; c_rxset = 1; c_txset = 1; c_areg = 1; c_txreg = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "rx_a forced", rx_a, 1'b1);
        chk("R10", "pad_o forced", pad_out, 1'b1);
        @(posedge clk); #1;
        gsr = 0;
        @(negedge clk);
        chk("R10", "rx_a held", rx_a, 1'b1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule